// File: doc/BRIEF.md
# Interrupt Mode Power Floor

This block decides whether the system is currently in interrupt mode and, while it is, keeps the operating-mode request from dropping below a minimum that software programs. Software sets three things through a control register: an arm bit, a choice of which interrupt lines may trigger entry, and a 3-bit floor mode. When the block is armed and a qualifying interrupt line is high, a sticky active flag sets. The flag stays set after the line drops. Only a software write to the status register clears it, and the same write can also set it.

The block sits between the operating-mode request that software issues and the clock and power sequencer that carries it out. Operating modes are 3-bit codes, and a larger code is a faster mode. While the flag is set, the block passes the larger of the software request and the floor. While the flag is clear, it passes the software request unchanged. Register access uses a single-cycle word bus: a write takes effect at the clock edge, and read data is combinational on the same cycle.

Top module: `int_mode_floor`

## Requirements
- R1: After reset, the control word reads 0, the status word reads 0, the active flag is 0, and the effective mode equals the software-requested mode.
- R2: The control register is at byte offset 0. It stores the arm bit at bit 0, the floor code at bits 3:1 and the line-select bit at bit 7. Bits 31:8 and 6:4 always read 0, and writing them has no effect.
- R3: While the arm bit is 0, neither interrupt line sets the active flag.
- R4: With the arm bit at 1 and line-select at 0, a high FIQ line sets the flag at the next clock edge, and the IRQ line is ignored.
- R5: With the arm bit at 1 and line-select at 1, a high FIQ line or a high IRQ line sets the flag at the next clock edge.
- R6: Once set, the active flag stays at 1 after the interrupt lines drop, until software writes 0 to it.
- R7: The status register is at byte offset 4, and the flag is bit 0. Writing 0 clears the flag and writing 1 sets it. Bits 31:1 read 0.
- R8: If a qualifying interrupt is high in the same cycle that software writes 0 to the status bit, the flag is 1 after that edge.
- R9: While the flag is 1, the effective mode equals the larger of the software request and the floor code. While the flag is 0, it equals the software request.
- R10: Reads from any offset other than 0 and 4 return 0, and writes to those offsets change no state. When no read is in progress, the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as a read |
| fiqReq | input | 1 | Fast interrupt request, level, already synchronous |
| irqReq | input | 1 | Normal interrupt request, level, already synchronous |
| swMode | input | 3 | Operating mode requested by software |
| effMode | output | 3 | Operating mode passed to the sequencer |
| intModeActive | output | 1 | Interrupt mode active flag |

## Verification
The properties assume that both interrupt lines are level signals that are already synchronous to the block clock. They also assume that bus accesses are word aligned, so that an offset matches a register only by exact equality. The stimulus drives every input only at the falling edge, uses only aligned offsets (0, 4, 8 and 12), and holds each line level for whole cycles. Within that envelope it still mixes writes and reads, reserved-bit patterns and both interrupt lines freely, including a status clear that coincides with a qualifying interrupt.

// File: rtl/imf_pkg.sv
package imf_pkg;

  localparam int DATA_W    = 32;
  localparam int MODE_W    = 3;

  // Control word field positions (software depends on these)
  localparam int ARM_BIT   = 0;
  localparam int FLOOR_LSB = 1;
  localparam int SEL_BIT   = 7;
  // Status word field position
  localparam int FLAG_BIT  = 0;

  typedef logic [MODE_W-1:0] mode_t;

  // Strobes from bus decode to the datapath
  typedef struct packed {
    logic wrCtrl;
    logic wrStat;
    logic rdCtrl;
    logic rdStat;
  } busStrobes_t;

  function automatic mode_t maxMode(input mode_t a, input mode_t b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/imf_bus_ctrl.sv
module imf_bus_ctrl
  import imf_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CTRL_OFS = 0,
  parameter int STAT_OFS = 4
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobes_t       strb
);

  localparam logic [ADDR_W-1:0] CtrlAddr = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] StatAddr = ADDR_W'(STAT_OFS);

  logic hitCtrl;
  logic hitStat;
  logic doWrite;
  logic doRead;

  always_comb begin
    hitCtrl = (busAddr == CtrlAddr);
    hitStat = (busAddr == StatAddr);
    doWrite = busSel && busWrite;
    doRead  = busSel && !busWrite;
  end

  always_comb begin
    strb        = '0;
    strb.wrCtrl = doWrite && hitCtrl;
    strb.wrStat = doWrite && hitStat;
    strb.rdCtrl = doRead  && hitCtrl;
    strb.rdStat = doRead  && hitStat;
  end

endmodule

// File: rtl/imf_datapath.sv
module imf_datapath
  import imf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              fiqReq,
  input  logic              irqReq,
  input  mode_t             swMode,
  output logic [DATA_W-1:0] busRdata,
  output mode_t             effMode,
  output logic              intModeActive,
  output logic              cfgEnable,
  output logic              cfgAnyIrq,
  output mode_t             cfgFloor
);

  // Configuration registers
  logic  armQ;
  logic  anyIrqQ;
  mode_t floorQ;
  logic  flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armQ    <= 1'b0;
      anyIrqQ <= 1'b0;
      floorQ  <= '0;
    end else if (strb.wrCtrl) begin
      armQ    <= busWdata[ARM_BIT];
      anyIrqQ <= busWdata[SEL_BIT];
      floorQ  <= busWdata[FLOOR_LSB +: MODE_W];
    end
  end

  // Interrupt qualification, using the settings held before any write this cycle
  logic qualIrq;
  logic setFlag;

  always_comb begin
    qualIrq = fiqReq || (anyIrqQ && irqReq);
    setFlag = armQ && qualIrq;
  end

  // Sticky flag: a hardware set wins over a software clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (setFlag) begin
      flagQ <= 1'b1;
    end else if (strb.wrStat) begin
      flagQ <= busWdata[FLAG_BIT];
    end
  end

  // Read data assembly; reserved bits tie to zero
  logic [DATA_W-1:0] ctrlWord;
  logic [DATA_W-1:0] statWord;

  always_comb begin
    ctrlWord                        = '0;
    ctrlWord[ARM_BIT]               = armQ;
    ctrlWord[FLOOR_LSB +: MODE_W]   = floorQ;
    ctrlWord[SEL_BIT]               = anyIrqQ;
    statWord                        = '0;
    statWord[FLAG_BIT]              = flagQ;
  end

  always_comb begin
    unique case (1'b1)
      strb.rdCtrl: busRdata = ctrlWord;
      strb.rdStat: busRdata = statWord;
      default:     busRdata = '0;
    endcase
  end

  // Mode override
  always_comb begin
    effMode = flagQ ? maxMode(swMode, floorQ) : swMode;
  end

  assign intModeActive = flagQ;
  assign cfgEnable     = armQ;
  assign cfgAnyIrq     = anyIrqQ;
  assign cfgFloor      = floorQ;

endmodule

// File: rtl/int_mode_floor.sv
module int_mode_floor
  import imf_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CTRL_OFS = 0,
  parameter int STAT_OFS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              fiqReq,
  input  logic              irqReq,
  input  logic [2:0]        swMode,
  output logic [2:0]        effMode,
  output logic              intModeActive
);

  busStrobes_t strb;
  logic        cfgEnable;
  logic        cfgAnyIrq;
  mode_t       cfgFloor;

  imf_bus_ctrl #(
    .ADDR_W  (ADDR_W),
    .CTRL_OFS(CTRL_OFS),
    .STAT_OFS(STAT_OFS)
  ) u_busCtrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strb    (strb)
  );

  imf_datapath u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .busWdata     (busWdata),
    .fiqReq       (fiqReq),
    .irqReq       (irqReq),
    .swMode       (swMode),
    .busRdata     (busRdata),
    .effMode      (effMode),
    .intModeActive(intModeActive),
    .cfgEnable    (cfgEnable),
    .cfgAnyIrq    (cfgAnyIrq),
    .cfgFloor     (cfgFloor)
  );

endmodule

// File: rtl/imf_checker.sv
module imf_checker #(
  parameter int ADDR_W   = 4,
  parameter int CTRL_OFS = 0,
  parameter int STAT_OFS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              fiqReq,
  input logic              irqReq,
  input logic [2:0]        swMode,
  input logic [2:0]        effMode,
  input logic              intModeActive,
  input logic              cfgEnable,
  input logic              cfgAnyIrq,
  input logic [2:0]        cfgFloor
);

  logic statWr;
  logic statWrOne;
  logic statWrZero;
  logic otherAddr;

  always_comb begin
    statWr     = busSel && busWrite && (busAddr == ADDR_W'(STAT_OFS));
    statWrOne  = statWr && busWdata[0];
    statWrZero = statWr && !busWdata[0];
    otherAddr  = (busAddr != ADDR_W'(STAT_OFS)) && (busAddr != ADDR_W'(CTRL_OFS));
  end

  assert_ctrl_reserved_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && busAddr == ADDR_W'(CTRL_OFS)) |->
      (busRdata[31:8] == '0 && busRdata[6:4] == '0));

  assert_no_entry_disarmed_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEnable && !intModeActive && !statWrOne) |=> !intModeActive);

  assert_irq_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgAnyIrq && !fiqReq && !intModeActive && !statWrOne) |=> !intModeActive);

  assert_irq_enters_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && cfgAnyIrq && irqReq) |=> intModeActive);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (intModeActive && !statWrZero) |=> intModeActive);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && fiqReq) |=> intModeActive);

  assert_floor_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    intModeActive |-> (effMode >= swMode && effMode >= cfgFloor));

  assert_passthrough_R9: assert property (@(posedge clk) disable iff (!rstN)
    !intModeActive |-> (effMode == swMode));

  assert_other_offset_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busSel || busWrite || otherAddr) |-> (busRdata == '0));

endmodule

bind int_mode_floor imf_checker #(
  .ADDR_W  (ADDR_W),
  .CTRL_OFS(CTRL_OFS),
  .STAT_OFS(STAT_OFS)
) u_imfChecker (
  .clk          (clk),
  .rstN         (rstN),
  .busSel       (busSel),
  .busWrite     (busWrite),
  .busAddr      (busAddr),
  .busWdata     (busWdata),
  .busRdata     (busRdata),
  .fiqReq       (fiqReq),
  .irqReq       (irqReq),
  .swMode       (swMode),
  .effMode      (effMode),
  .intModeActive(intModeActive),
  .cfgEnable    (cfgEnable),
  .cfgAnyIrq    (cfgAnyIrq),
  .cfgFloor     (cfgFloor)
);

// File: tb/test_int_mode_floor.sv
module test_int_mode_floor;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        fiqReq = 1'b0;
  logic        irqReq = 1'b0;
  logic [2:0]  swMode = '0;
  logic [2:0]  effMode;
  logic        intModeActive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model of the registers
  bit       mArm = 0;
  bit       mAny = 0;
  bit [2:0] mFloor = 0;
  bit       mFlag = 0;

  always #5 clk = ~clk;

  int_mode_floor i_int_mode_floor (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .fiqReq(fiqReq), .irqReq(irqReq), .swMode(swMode),
    .effMode(effMode), .intModeActive(intModeActive)
  );

  function automatic logic [31:0] expRdata();
    if (!busSel || busWrite) return 32'h0;
    if (busAddr == 4'd0) return {24'h0, mAny, 3'b000, mFloor, mArm};
    if (busAddr == 4'd4) return {31'h0, mFlag};
    return 32'h0;
  endfunction

  function automatic logic [2:0] expMode();
    if (mFlag && mFloor > swMode) return mFloor;
    return swMode;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle at the falling edge, compare against the model, advance the model.
  task automatic cycle(input bit sel, input bit wr, input logic [3:0] addr,
                       input logic [31:0] wd, input bit fiq, input bit irq,
                       input logic [2:0] sw);
    bit setC;
    busSel = sel; busWrite = wr; busAddr = addr; busWdata = wd;
    fiqReq = fiq; irqReq = irq; swMode = sw;
    #1;
    check((addr == 4'd0) ? "R2 rdata" : (addr == 4'd4) ? "R7 rdata" : "R10 rdata",
          busRdata, expRdata());
    check("R9 effMode", 32'(effMode), 32'(expMode()));
    check("R6 flag", 32'(intModeActive), 32'(mFlag));
    setC = mArm && (fiq || (mAny && irq));
    if (setC) mFlag = 1;
    else if (sel && wr && addr == 4'd4) mFlag = wd[0];
    if (sel && wr && addr == 4'd0) begin
      mArm = wd[0]; mFloor = wd[3:1]; mAny = wd[7];
    end
    @(negedge clk);
  endtask

  task automatic idle(input bit fiq, input bit irq, input logic [2:0] sw);
    cycle(0, 0, 4'd0, 32'h0, fiq, irq, sw);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    swMode = 3'd3; busSel = 1; busWrite = 0; busAddr = 4'd0; #1;
    check("R1 ctrl", busRdata, 32'h0);
    busAddr = 4'd4; #1;
    check("R1 stat", busRdata, 32'h0);
    check("R1 flag", 32'(intModeActive), 32'h0);
    check("R1 effMode", 32'(effMode), 32'd3);
    @(negedge clk);

    // R3: disarmed, both lines high
    idle(1, 1, 3'd1);
    idle(1, 1, 3'd1);
    check("R3 no entry", 32'(intModeActive), 32'h0);

    // R2: arm, FIQ only, floor 5, reserved bits set
    cycle(1, 1, 4'd0, 32'hFFFF_FF7B, 0, 0, 3'd1);
    cycle(1, 0, 4'd0, 32'h0, 0, 0, 3'd1);
    check("R2 readback", {24'h0, 1'b0, 3'b0, mFloor, mArm}, 32'h0B);
    busSel = 1; busWrite = 0; busAddr = 4'd0; #1;
    check("R2 reserved zero", busRdata, 32'h0000_000B);
    @(negedge clk);

    // R4: IRQ ignored with line-select 0
    idle(0, 1, 3'd2);
    idle(0, 1, 3'd2);
    check("R4 irq ignored", 32'(intModeActive), 32'h0);
    idle(1, 0, 3'd2);
    check("R4 fiq enters", 32'(intModeActive), 32'h1);

    // R6 sticky and R9 override
    idle(0, 0, 3'd2);
    check("R6 sticky", 32'(intModeActive), 32'h1);
    check("R9 floor", 32'(effMode), 32'd5);
    swMode = 3'd6; #1;
    check("R9 faster request", 32'(effMode), 32'd6);
    @(negedge clk);

    // R7: software clear and set
    cycle(1, 1, 4'd4, 32'hFFFF_FFFE, 0, 0, 3'd2);
    check("R7 clear", 32'(intModeActive), 32'h0);
    check("R9 passthrough", 32'(effMode), 32'd2);
    cycle(1, 1, 4'd4, 32'h0000_0001, 0, 0, 3'd2);
    check("R7 set", 32'(intModeActive), 32'h1);

    // R8: clear coinciding with qualifying FIQ
    cycle(1, 1, 4'd4, 32'h0, 1, 0, 3'd2);
    check("R8 set wins", 32'(intModeActive), 32'h1);
    cycle(1, 1, 4'd4, 32'h0, 0, 0, 3'd2);
    check("R7 clear again", 32'(intModeActive), 32'h0);

    // R5: line-select 1, IRQ enters
    cycle(1, 1, 4'd0, 32'h0000_0083, 0, 0, 3'd0);
    idle(0, 1, 3'd0);
    check("R5 irq enters", 32'(intModeActive), 32'h1);
    check("R9 floor 1", 32'(effMode), 32'd1);

    // R10: other offsets
    cycle(1, 1, 4'd8, 32'hFFFF_FFFF, 0, 0, 3'd0);
    cycle(1, 1, 4'd12, 32'h0, 0, 0, 3'd0);
    busSel = 1; busWrite = 0; busAddr = 4'd8; #1;
    check("R10 read other", busRdata, 32'h0);
    busAddr = 4'd0; #1;
    check("R10 ctrl untouched", busRdata, 32'h83);
    check("R10 flag untouched", 32'(intModeActive), 32'h1);
    @(negedge clk);

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  a;
      logic [31:0] wd;
      bit          sel, wr;
      a   = 4'(($urandom % 4) * 4);
      wd  = $urandom;
      if (a == 4'd4 && ($urandom % 2) == 0) wd[31:1] = '0;
      sel = ($urandom % 3) != 0;
      wr  = ($urandom % 2) != 0;
      cycle(sel, wr, a, wd, ($urandom % 8) == 0, ($urandom % 5) == 0, 3'($urandom));
    end

    finishRun();
  end

endmodule